// File: doc/BRIEF.md
# Paged DMA Address Generator

This block builds full memory addresses for a four-channel DMA engine. Each channel keeps a 16-bit low address counter, a remaining-transfer counter and a separate page latch. The page latch supplies the upper address bits. Software programs these values through a small write port that carries a channel number and a field select.

An external grant picks at most one channel. While the granted channel is busy, the block drives that channel's page bits placed directly above its low address. The two parts are simply joined, with no arithmetic between them. Each step strobe advances the active channel by one transfer.

The page latch never takes a carry from the low counter. A transfer that runs past 0xFFFF therefore wraps back to the start of the same 64 KiB region, and a sticky per-channel flag records that this happened. By default the page is 8 bits wide, giving a 24-bit address. A parameter widens the page to 16 bits for a 32-bit address.

Top module: `pdma_addr_gen`

## Requirements
- R1: After reset, `addr` is zero, and `addr_valid`, `tc`, every `wrap_flag` bit and every `chan_busy` bit are 0.
- R2: When `grant` selects exactly one channel and that channel is busy, `addr_valid` is 1 and `addr` equals {page, low address} of that channel. The page occupies bits ADDR_W-1..16 and the low address occupies bits 15..0.
- R3: When no granted channel is busy, `addr_valid` is 0 and `addr` is zero.
- R4: A `step` applied while a channel is active increments that channel's low address by one at the clock edge. The state of other channels is left unchanged.
- R5: When the low address steps past 0xFFFF it becomes 0x0000, and the page value does not change.
- R6: A channel's `wrap_flag` is set by a step taken from low address 0xFFFF. It stays set until a base-address write to that channel while the channel is idle.
- R7: A count value N yields N+1 steps. The step taken at remaining count 0 ends the transfer: in the next cycle `tc` is 1 for exactly that cycle, and the channel's `chan_busy` bit is 0.
- R8: Writes of any field to a busy channel are ignored, so its page, low address and count hold for the whole transfer.
- R9: Field select encoding: 0 loads the low address from `wr_data[15:0]` and clears the wrap flag; 1 loads the page from `wr_data[PAGE_W-1:0]`; 2 loads the count and makes the channel busy; 3 has no effect.
- R10: A `step` while no granted channel is busy changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | 2 | Channel addressed by the write |
| wr_sel | input | 2 | Field select (0 base, 1 page, 2 count, 3 none) |
| wr_data | input | 16 | Write data |
| grant | input | 4 | One-hot channel grant, all zero when nothing is granted |
| step | input | 1 | Transfer-step strobe for the active channel |
| addr | output | 24 | Full address {page, low} of the active channel |
| addr_valid | output | 1 | A granted channel is busy |
| tc | output | 1 | Terminal count pulse |
| wrap_flag | output | 4 | Sticky per-channel 64 KiB wrap flags |
| chan_busy | output | 4 | Per-channel busy (programmed, not finished) |

## Verification
The assertions assume that `grant` is one-hot or zero, and that `rst_n` is low at time zero. The stimulus only ever drives `grant` with zero or a single set bit, and it starts under reset. Writes to busy channels are deliberately issued during transfers. These writes, together with the reserved field code, confirm through `addr` and the status outputs that the page latch holds. The wrap case starts a transfer just below 0xFFFF so that the wrap, the unchanged page and the sticky flag are all visible at the ports.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int LOW_W = 16;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_PAGE  = 2'd1,
    FLD_COUNT = 2'd2,
    FLD_NONE  = 2'd3
  } fld_e;
endpackage

// File: rtl/pdma_chan.sv
module pdma_chan
  import pdma_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              step_en,
  output logic [LOW_W-1:0]  low,
  output logic [PAGE_W-1:0] page,
  output logic              busy,
  output logic              wrap,
  output logic              tc_hit
);

  logic [LOW_W-1:0]  low_q, low_d;
  logic [LOW_W-1:0]  cnt_q, cnt_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              busy_q, busy_d;
  logic              wrap_q, wrap_d;
  logic              low_en, cnt_en, page_en, busy_en, wrap_en;

  always_comb begin
    low_d   = low_q;
    cnt_d   = cnt_q;
    page_d  = page_q;
    busy_d  = busy_q;
    wrap_d  = wrap_q;
    low_en  = 1'b0;
    cnt_en  = 1'b0;
    page_en = 1'b0;
    busy_en = 1'b0;
    wrap_en = 1'b0;
    if (wr_hit && !busy_q) begin
      unique case (wr_sel)
        FLD_BASE: begin
          low_d   = wr_data[LOW_W-1:0];
          low_en  = 1'b1;
          wrap_d  = 1'b0;
          wrap_en = 1'b1;
        end
        FLD_PAGE: begin
          page_d  = wr_data[PAGE_W-1:0];
          page_en = 1'b1;
        end
        FLD_COUNT: begin
          cnt_d   = wr_data[LOW_W-1:0];
          cnt_en  = 1'b1;
          busy_d  = 1'b1;
          busy_en = 1'b1;
        end
        default: ;
      endcase
    end
    if (step_en) begin
      low_d  = low_q + 1'b1;
      low_en = 1'b1;
      if (low_q == {LOW_W{1'b1}}) begin
        wrap_d  = 1'b1;
        wrap_en = 1'b1;
      end
      if (cnt_q == '0) begin
        busy_d  = 1'b0;
        busy_en = 1'b1;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      cnt_q  <= '0;
      page_q <= '0;
      busy_q <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      if (low_en)  low_q  <= low_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (page_en) page_q <= page_d;
      if (busy_en) busy_q <= busy_d;
      if (wrap_en) wrap_q <= wrap_d;
    end
  end

  assign low    = low_q;
  assign page   = page_q;
  assign busy   = busy_q;
  assign wrap   = wrap_q;
  assign tc_hit = step_en && (cnt_q == '0);

  // R8: page latch held while transfer runs
  p_page_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(page));

  // R4: each step advances the low counter by one
  p_step_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (low == LOW_W'($past(low) + 1'b1)));

  // R5: wrap leaves the page unchanged
  p_wrap_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && low == {LOW_W{1'b1}}) |=> (low == '0 && $stable(page)));

  // R6: flag set on wrap and sticky until a base write
  p_wrap_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && low == {LOW_W{1'b1}}) |=> wrap);
  p_wrap_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !(wr_hit && wr_sel == FLD_BASE)) |=> wrap);

  // R7: final step ends the transfer
  p_tc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit |=> !busy);

endmodule

// File: rtl/pdma_addr_mux.sv
module pdma_addr_mux
  import pdma_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int PAGE_W = 8,
  localparam int ADDR_W = LOW_W + PAGE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        grant,
  input  logic [NCH-1:0]        busy,
  input  logic [NCH*LOW_W-1:0]  low_flat,
  input  logic [NCH*PAGE_W-1:0] page_flat,
  output logic [NCH-1:0]        active,
  output logic [ADDR_W-1:0]     addr,
  output logic                  addr_valid
);

  always_comb begin
    active = grant & busy;
    addr   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (active[i]) begin
        addr = addr | {page_flat[i*PAGE_W +: PAGE_W], low_flat[i*LOW_W +: LOW_W]};
      end
    end
    addr_valid = |active;
  end

  // R3: idle output is zero
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> (addr == '0));

  // R2: a valid address comes from exactly one granted busy channel
  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> ($onehot(grant) && (grant & busy) != '0));

endmodule

// File: rtl/pdma_addr_gen.sv
module pdma_addr_gen
  import pdma_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int PAGE_W = 8,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = LOW_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NCH-1:0]    grant,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_valid,
  output logic              tc,
  output logic [NCH-1:0]    wrap_flag,
  output logic [NCH-1:0]    chan_busy
);

  logic [NCH*LOW_W-1:0]  low_flat;
  logic [NCH*PAGE_W-1:0] page_flat;
  logic [NCH-1:0]        active;
  logic [NCH-1:0]        tc_hit;
  logic                  tc_q, tc_d;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic wr_hit_g;
    assign wr_hit_g = wr_en && (wr_chan == CH_W'(g));
    pdma_chan #(.PAGE_W(PAGE_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit_g),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .step_en (step && active[g]),
      .low     (low_flat[g*LOW_W +: LOW_W]),
      .page    (page_flat[g*PAGE_W +: PAGE_W]),
      .busy    (chan_busy[g]),
      .wrap    (wrap_flag[g]),
      .tc_hit  (tc_hit[g])
    );
  end

  pdma_addr_mux #(.NCH(NCH), .PAGE_W(PAGE_W)) u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (grant),
    .busy       (chan_busy),
    .low_flat   (low_flat),
    .page_flat  (page_flat),
    .active     (active),
    .addr       (addr),
    .addr_valid (addr_valid)
  );

  assign tc_d = |tc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc_q <= 1'b0;
    else        tc_q <= tc_d;
  end

  assign tc = tc_q;

  // R10: a step without an active channel changes no busy state
  p_idle_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !addr_valid && !wr_en) |=> ($stable(chan_busy) && $stable(wrap_flag)));

  // R7: terminal count follows an ending step
  p_tc_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> $past(step && addr_valid));

endmodule

// File: tb/pdma_addr_gen_tb.sv
`timescale 1ns/1ps
module pdma_addr_gen_tb;
  localparam int NCH = 4;
  localparam int PAGE_W = 8;
  localparam int ADDR_W = 16 + PAGE_W;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [1:0] wr_chan;
  logic [1:0] wr_sel;
  logic [15:0] wr_data;
  logic [NCH-1:0] grant;
  logic step;
  logic [ADDR_W-1:0] addr;
  logic addr_valid, tc;
  logic [NCH-1:0] wrap_flag, chan_busy;

  always #10 clk = ~clk;

  pdma_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
    .wr_sel(wr_sel), .wr_data(wr_data), .grant(grant), .step(step),
    .addr(addr), .addr_valid(addr_valid), .tc(tc),
    .wrap_flag(wrap_flag), .chan_busy(chan_busy)
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic valid;
    logic tc;
    logic [NCH-1:0] wrap;
    logic [NCH-1:0] busy;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_low [NCH];
  logic [15:0] m_cnt [NCH];
  logic [PAGE_W-1:0] m_page [NCH];
  logic [NCH-1:0] m_busy, m_wrap;
  logic m_tc;

  task automatic chk(string what, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: compares outputs against queued expectations away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk("addr", it.tag, 32'(addr), 32'(it.addr));
        chk("addr_valid", it.tag, 32'(addr_valid), 32'(it.valid));
        chk("tc", it.tag, 32'(tc), 32'(it.tc));
        chk("wrap_flag", it.tag, 32'(wrap_flag), 32'(it.wrap));
        chk("chan_busy", it.tag, 32'(chan_busy), 32'(it.busy));
      end
    end
  end

  // driver: apply one cycle, push expectation from model, advance model
  task automatic cyc(bit we, int ch, int sel, int data, logic [NCH-1:0] g, bit st, string tag);
    item_t it;
    logic [NCH-1:0] act;
    @(negedge clk);
    wr_en = we; wr_chan = 2'(ch); wr_sel = 2'(sel); wr_data = 16'(data);
    grant = g; step = st;
    act = g & m_busy;
    it.addr = '0;
    for (int i = 0; i < NCH; i++)
      if (act[i]) it.addr = {m_page[i], m_low[i]};
    it.valid = |act;
    it.tc = m_tc;
    it.wrap = m_wrap;
    it.busy = m_busy;
    it.tag = tag;
    q.push_back(it);
    @(posedge clk);
    m_tc = 1'b0;
    if (we && !m_busy[ch]) begin
      case (sel)
        0: begin m_low[ch] = 16'(data); m_wrap[ch] = 1'b0; end
        1: m_page[ch] = PAGE_W'(data);
        2: begin m_cnt[ch] = 16'(data); m_busy[ch] = 1'b1; end
        default: ;
      endcase
    end
    if (st) begin
      for (int i = 0; i < NCH; i++) begin
        if (act[i]) begin
          if (m_low[i] == 16'hFFFF) m_wrap[i] = 1'b1;
          m_low[i] = m_low[i] + 16'd1;
          if (m_cnt[i] == 16'd0) begin
            m_busy[i] = 1'b0;
            m_tc = 1'b1;
          end else m_cnt[i] = m_cnt[i] - 16'd1;
        end
      end
    end
  endtask

  task automatic idle(logic [NCH-1:0] g, string tag);
    cyc(0, 0, 0, 0, g, 0, tag);
  endtask

  task automatic prog(int ch, int base, int pg, int cnt, string tag);
    cyc(1, ch, 0, base, '0, 0, tag);
    cyc(1, ch, 1, pg, '0, 0, tag);
    cyc(1, ch, 2, cnt, '0, 0, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      m_low[i] = '0; m_cnt[i] = '0; m_page[i] = '0;
    end
    m_busy = '0; m_wrap = '0; m_tc = 1'b0;
    rst_n = 1'b0; wr_en = 0; wr_chan = 0; wr_sel = 0; wr_data = 0;
    grant = '0; step = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    idle('0, "R1");
    idle(4'b1111 & 4'b0001, "R1");

    // R9: reserved field has no effect on an idle channel
    cyc(1, 3, 3, 16'hBEEF, '0, 0, "R9");
    idle(4'b1000, "R9");

    // channel 1: base 0x1234, page 0x12, count 2 -> three steps
    prog(1, 16'h1234, 8'h12, 2, "R9");
    idle('0, "R3");
    cyc(0, 0, 0, 0, '0, 1, "R10");
    cyc(0, 0, 0, 0, 4'b0001, 1, "R10");
    idle(4'b0010, "R2");
    cyc(0, 0, 0, 0, 4'b0010, 1, "R4");
    cyc(1, 1, 1, 8'h77, 4'b0010, 1, "R8");
    cyc(1, 1, 0, 16'h0000, 4'b0010, 1, "R7");
    idle(4'b0010, "R7");
    idle(4'b0010, "R7");

    // channel 2: crosses the 64 KiB boundary, page held
    prog(2, 16'hFFFE, 8'h34, 3, "R9");
    prog(0, 16'h0100, 8'hAB, 0, "R9");
    idle(4'b0100, "R2");
    cyc(0, 0, 0, 0, 4'b0100, 1, "R4");
    cyc(0, 0, 0, 0, 4'b0100, 1, "R5");
    cyc(1, 2, 1, 8'h99, 4'b0100, 0, "R8");
    cyc(1, 2, 0, 16'h5555, 4'b0100, 1, "R6");
    cyc(1, 2, 2, 16'h0010, 4'b0100, 1, "R8");
    idle(4'b0100, "R7");
    idle('0, "R6");

    // channel 0 untouched while channel 2 ran
    idle(4'b0001, "R4");
    cyc(0, 0, 0, 0, 4'b0001, 1, "R7");
    idle(4'b0001, "R7");

    // base write on idle channel 2 clears its wrap flag
    cyc(1, 2, 0, 16'h0042, '0, 0, "R6");
    idle('0, "R6");
    idle(4'b0010, "R3");
    idle('0, "R3");

    @(negedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule